// File: doc/BRIEF.md
# Byte-Serial SPI Memory Engine

This block is the command engine of a serial memory device. It works on whole bytes: the bit shifting and the serial clock are handled elsewhere. Every one-cycle transfer strobe hands the engine one received byte, and the engine places one reply byte on its output register on the following cycle.

The engine runs either as an EEPROM with one, two or three address bytes, or as a flash device with three address bytes. It decodes an opcode, collects the address bytes, and then streams data bytes to or from an on-chip byte array. A write-enable latch gates every write command. A separate reset-communication strobe, pulsed when chip-select is released, ends the current command and returns the engine to opcode decode.

Top module: `spi_mem_engine`

## Requirements
- R1: A transfer is a one-cycle pulse on `xfer_i`. `dout_o` takes the reply on the clock edge that samples the pulse, and it holds its value in every cycle that has no transfer.
- R2: When no command is active, a received byte is decoded as an opcode. Code 0x00 and unrecognised codes change no state. Every opcode byte, and every address byte, is echoed on `dout_o`.
- R3: The opcodes are: read 0x03, write-enable 0x06, write-disable 0x04, read-status 0x05. Write is 0x02 in EEPROM modes and 0x0A in flash mode, where 0x02 is unrecognised. In EEPROM modes, 0x0A is a write and 0x0B is a read, and both start the address at 1 instead of 0.
- R4: A read or write takes N address bytes, most significant first. Each byte is OR-ed into its byte lane of an address that starts cleared (or seeded with 1). `mode_i` selects N: 2'b00 is flash with N=3, and 2'b01, 2'b10 and 2'b11 are EEPROM with N=1, 2 and 3.
- R5: After the address phase, every byte is data. A read returns the stored byte at the address. A write stores the received byte at the address and echoes it. The address then increments, and this repeats until communication is reset.
- R6: A data byte whose address is at or above DEPTH changes nothing. The address does not advance, and the received byte is echoed.
- R7: Write-enable sets the latch only while `writable_i` is 1. Write-disable always clears it.
- R8: A write opcode that arrives while the latch is clear returns 0x00, and the engine stays in opcode decode.
- R9: In status mode, every following byte returns the status. The status is 0x00 in flash mode. In EEPROM modes it is `writable_i` in bit 1, with all other bits 0.
- R10: `com_reset_i` clears only the active command. The write-enable latch and the stored bytes are kept.
- R11: After reset, `dout_o` is 0x00, no command is active and the latch is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Device mode: 00 flash, 01/10/11 EEPROM with 1/2/3 address bytes |
| writable_i | input | 1 | Storage may be written |
| com_reset_i | input | 1 | End the current command (chip-select released) |
| xfer_i | input | 1 | One-cycle byte transfer strobe |
| din_i | input | 8 | Received byte |
| dout_o | output | 8 | Reply byte, registered |

## Verification
The hardest state to reach is a data phase whose address has run past the end of the array. The bench reaches it in two ways. In the first, a two-byte EEPROM address of 0x0100 is sent directly. In the second, a one-byte EEPROM write starts at 0xFF and keeps streaming until the address increments to 256. After that, a fresh read from 0xFF shows that the byte one beyond it was never stored. The bench also reaches the high read and write variants, which seed the address with 1. For these it writes through one variant and reads back through another.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    localparam int ACC_W = 24;

    typedef enum logic [1:0] {
        CMD_IDLE   = 2'd0,
        CMD_READ   = 2'd1,
        CMD_WRITE  = 2'd2,
        CMD_STATUS = 2'd3
    } op_e;

    localparam logic [1:0] MODE_FLASH = 2'd0;

    localparam logic [7:0] OPC_READ   = 8'h03;
    localparam logic [7:0] OPC_WREN   = 8'h06;
    localparam logic [7:0] OPC_WRDI   = 8'h04;
    localparam logic [7:0] OPC_STATUS = 8'h05;
    localparam logic [7:0] OPC_WR_EE  = 8'h02;
    localparam logic [7:0] OPC_WR_HI  = 8'h0A;
    localparam logic [7:0] OPC_RD_HI  = 8'h0B;

    typedef struct packed {
        op_e              op;
        logic [ACC_W-1:0] addr;
        logic [1:0]       cnt;
        logic             wel;
        logic [7:0]       dout;
    } eng_state_t;

endpackage

// File: rtl/spi_mem_ram.sv
module spi_mem_ram #(
    parameter int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [7:0]       wdata_i,
    output logic [7:0]       rdata_o
);
    logic [7:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) cells_q[idx_i] <= wdata_i;
    end

    assign rdata_o = cells_q[idx_i];
endmodule

// File: rtl/spi_mem_decode.sv
module spi_mem_decode (
    input  logic [1:0] mode_i,
    input  logic       writable_i,
    input  logic [7:0] byte_i,
    output logic       rd_o,
    output logic       wr_o,
    output logic       seed_one_o,
    output logic       set_wel_o,
    output logic       clr_wel_o,
    output logic       status_o,
    output logic [1:0] addr_bytes_o
);
    import spi_mem_pkg::*;

    logic flash;
    assign flash = (mode_i == MODE_FLASH);

    always_comb begin
        addr_bytes_o = flash ? 2'd3 : mode_i;
        rd_o         = (byte_i == OPC_READ) || (!flash && byte_i == OPC_RD_HI);
        wr_o         = flash ? (byte_i == OPC_WR_HI)
                             : (byte_i == OPC_WR_EE || byte_i == OPC_WR_HI);
        seed_one_o   = !flash && (byte_i == OPC_WR_HI || byte_i == OPC_RD_HI);
        set_wel_o    = (byte_i == OPC_WREN) && writable_i;
        clr_wel_o    = (byte_i == OPC_WRDI);
        status_o     = (byte_i == OPC_STATUS);
    end
endmodule

// File: rtl/spi_mem_next.sv
module spi_mem_next #(
    parameter int DEPTH = 256
) (
    input  spi_mem_pkg::eng_state_t cur_i,
    input  logic [1:0]              mode_i,
    input  logic                    writable_i,
    input  logic                    com_reset_i,
    input  logic                    xfer_i,
    input  logic [7:0]              din_i,
    input  logic [7:0]              rdata_i,
    output spi_mem_pkg::eng_state_t nxt_o,
    output logic                    mem_we_o
);
    import spi_mem_pkg::*;

    localparam logic [ACC_W-1:0] LIMIT = ACC_W'(DEPTH);

    logic       dc_rd, dc_wr, dc_seed, dc_set, dc_clr, dc_st;
    logic [1:0] dc_n;
    logic [ACC_W-1:0] lane_d;
    logic             in_range;

    spi_mem_decode u_dec (
        .mode_i       (mode_i),
        .writable_i   (writable_i),
        .byte_i       (din_i),
        .rd_o         (dc_rd),
        .wr_o         (dc_wr),
        .seed_one_o   (dc_seed),
        .set_wel_o    (dc_set),
        .clr_wel_o    (dc_clr),
        .status_o     (dc_st),
        .addr_bytes_o (dc_n)
    );

    assign in_range = (cur_i.addr < LIMIT);

    always_comb begin
        case (cur_i.cnt)
            2'd1:    lane_d = {16'b0, din_i};
            2'd2:    lane_d = {8'b0, din_i, 8'b0};
            default: lane_d = {din_i, 16'b0};
        endcase
    end

    always_comb begin
        nxt_o    = cur_i;
        mem_we_o = 1'b0;
        if (com_reset_i) begin
            nxt_o.op = CMD_IDLE;
        end else if (xfer_i) begin
            nxt_o.dout = din_i;
            case (cur_i.op)
                CMD_READ, CMD_WRITE: begin
                    if (cur_i.cnt != 2'd0) begin
                        nxt_o.cnt  = cur_i.cnt - 2'd1;
                        nxt_o.addr = cur_i.addr | lane_d;
                    end else if (in_range) begin
                        nxt_o.addr = cur_i.addr + 1'b1;
                        if (cur_i.op == CMD_READ) nxt_o.dout = rdata_i;
                        else                      mem_we_o   = 1'b1;
                    end
                end
                CMD_STATUS: begin
                    nxt_o.dout = (mode_i == MODE_FLASH) ? 8'h00
                                                        : {6'b0, writable_i, 1'b0};
                end
                default: begin
                    if (dc_set) nxt_o.wel = 1'b1;
                    if (dc_clr) nxt_o.wel = 1'b0;
                    if (dc_st)  nxt_o.op  = CMD_STATUS;
                    if (dc_rd || (dc_wr && cur_i.wel)) begin
                        nxt_o.op   = dc_rd ? CMD_READ : CMD_WRITE;
                        nxt_o.addr = {{(ACC_W-1){1'b0}}, dc_seed};
                        nxt_o.cnt  = dc_n;
                    end
                    if (dc_wr && !cur_i.wel) nxt_o.dout = 8'h00;
                end
            endcase
        end
    end
endmodule

// File: rtl/spi_mem_engine.sv
module spi_mem_engine #(
    parameter int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       writable_i,
    input  logic       com_reset_i,
    input  logic       xfer_i,
    input  logic [7:0] din_i,
    output logic [7:0] dout_o
);
    import spi_mem_pkg::*;

    eng_state_t state_d, state_q;
    logic       mem_we;
    logic [7:0] rdata;

    op_e              op_q;
    logic [ACC_W-1:0] addr_q;
    logic [1:0]       cnt_q;
    logic             wel_q;

    spi_mem_next #(.DEPTH(DEPTH)) u_next (
        .cur_i       (state_q),
        .mode_i      (mode_i),
        .writable_i  (writable_i),
        .com_reset_i (com_reset_i),
        .xfer_i      (xfer_i),
        .din_i       (din_i),
        .rdata_i     (rdata),
        .nxt_o       (state_d),
        .mem_we_o    (mem_we)
    );

    spi_mem_ram #(.DEPTH(DEPTH)) u_ram (
        .clk     (clk),
        .we_i    (mem_we),
        .idx_i   (state_q.addr[IDX_W-1:0]),
        .wdata_i (din_i),
        .rdata_o (rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '{op: CMD_IDLE, addr: '0, cnt: 2'd0, wel: 1'b0, dout: 8'h00};
        else        state_q <= state_d;
    end

    assign dout_o = state_q.dout;
    assign op_q   = state_q.op;
    assign addr_q = state_q.addr;
    assign cnt_q  = state_q.cnt;
    assign wel_q  = state_q.wel;
endmodule

// File: rtl/spi_mem_engine_chk.sv
module spi_mem_engine_chk #(
    parameter int DEPTH = 256
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [1:0]                     mode_i,
    input logic                           writable_i,
    input logic                           com_reset_i,
    input logic                           xfer_i,
    input logic [7:0]                     din_i,
    input logic [7:0]                     dout_o,
    input spi_mem_pkg::op_e               op_q,
    input logic [spi_mem_pkg::ACC_W-1:0]  addr_q,
    input logic [1:0]                     cnt_q,
    input logic                           wel_q
);
    import spi_mem_pkg::*;

    localparam logic [ACC_W-1:0] LIMIT = ACC_W'(DEPTH);

    AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_i |=> $stable(dout_o)); // R1

    AST_COMRST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        com_reset_i |=> (op_q == CMD_IDLE)); // R10

    AST_COMRST_KEEP_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        com_reset_i |=> $stable(wel_q)); // R10

    AST_WEL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel_q) |-> $past(xfer_i && !com_reset_i && op_q == CMD_IDLE
                               && din_i == 8'h06 && writable_i)); // R7

    AST_REFUSED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_i && !com_reset_i && op_q == CMD_IDLE && !wel_q &&
         (din_i == 8'h0A || (mode_i != 2'd0 && din_i == 8'h02)))
        |=> (dout_o == 8'h00 && op_q == CMD_IDLE)); // R8

    AST_STATUS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_i && !com_reset_i && op_q == CMD_STATUS)
        |=> ((dout_o & 8'hFD) == 8'h00)); // R9

    AST_OOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_i && !com_reset_i && (op_q == CMD_READ || op_q == CMD_WRITE)
         && cnt_q == 2'd0 && addr_q >= LIMIT)
        |=> $stable(addr_q)); // R6
endmodule

bind spi_mem_engine spi_mem_engine_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .writable_i  (writable_i),
    .com_reset_i (com_reset_i),
    .xfer_i      (xfer_i),
    .din_i       (din_i),
    .dout_o      (dout_o),
    .op_q        (op_q),
    .addr_q      (addr_q),
    .cnt_q       (cnt_q),
    .wel_q       (wel_q)
);

// File: tb/sim_spi_mem_engine.sv
`timescale 1ns/1ps
module sim_spi_mem_engine;
    localparam logic [1:0] M_FLASH = 2'd0;
    localparam logic [1:0] M_EE1   = 2'd1;
    localparam logic [1:0] M_EE2   = 2'd2;
    localparam logic [1:0] M_EE3   = 2'd3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = M_EE1;
    logic       writable = 1'b0;
    logic       com_reset = 1'b0;
    logic       xfer = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [7:0] ref_mem [256];

    always #2.5 clk = ~clk;

    spi_mem_engine u0 (
        .clk (clk), .rst_n (rst_n), .mode_i (mode), .writable_i (writable),
        .com_reset_i (com_reset), .xfer_i (xfer), .din_i (din), .dout_o (dout)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic xb(input logic [7:0] b, output logic [7:0] r);
        @(negedge clk);
        din  = b;
        xfer = 1'b1;
        @(negedge clk);
        xfer = 1'b0;
        r    = dout;
    endtask

    task automatic xc(input logic [7:0] b, input logic [7:0] exp, input string req);
        logic [7:0] r;
        xb(b, r);
        chk(req, r, exp);
    endtask

    task automatic end_com();
        @(negedge clk);
        com_reset = 1'b1;
        @(negedge clk);
        com_reset = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 reset dout", dout, 8'h00);
        mode = M_EE1; writable = 1'b1;
        xc(8'h02, 8'h00, "R11 latch clear after reset");
    endtask

    task automatic t_idle();
        logic [7:0] r;
        mode = M_EE1;
        xc(8'h00, 8'h00, "R2 no-op echo");
        xc(8'h5A, 8'h5A, "R2 unknown echo");
        repeat (3) @(negedge clk);
        chk("R1 output holds without transfer", dout, 8'h5A);
        xb(8'hC7, r);
        chk("R2 still decoding", r, 8'hC7);
    endtask

    task automatic t_refused();
        mode = M_EE1; writable = 1'b1;
        xc(8'h02, 8'h00, "R8 refused write returns zero");
        xc(8'h77, 8'h77, "R8 stays in decode");
        writable = 1'b0;
        xc(8'h06, 8'h06, "R7 wren echo");
        xc(8'h02, 8'h00, "R7 wren ignored when not writable");
        writable = 1'b1;
        xc(8'h06, 8'h06, "R7 wren echo");
        xc(8'h02, 8'h02, "R7 wren sets latch");
        end_com();
    endtask

    task automatic t_ee1();
        mode = M_EE1;
        xc(8'h02, 8'h02, "R3 ee write opcode");
        xc(8'h10, 8'h10, "R4 address echo");
        for (int i = 0; i < 3; i++) begin
            xc(8'hA1 + 8'(i), 8'hA1 + 8'(i), "R5 write data echo");
            ref_mem[8'h10 + i] = 8'hA1 + 8'(i);
        end
        end_com();
        xc(8'h03, 8'h03, "R3 read opcode");
        xc(8'h10, 8'h10, "R4 address echo");
        for (int i = 0; i < 3; i++)
            xc(8'hFF, ref_mem[8'h10 + i], "R5 read data, one address byte");
        end_com();
    endtask

    task automatic t_ee2_high();
        mode = M_EE2;
        xc(8'h02, 8'h02, "R3 ee write opcode");
        xc(8'h00, 8'h00, "R4 addr hi");
        xc(8'h40, 8'h40, "R4 addr lo");
        xc(8'h11, 8'h11, "R5 write");
        xc(8'h22, 8'h22, "R5 write");
        ref_mem[8'h40] = 8'h11; ref_mem[8'h41] = 8'h22;
        end_com();
        xc(8'h0A, 8'h0A, "R3 high write opcode");
        xc(8'h00, 8'h00, "R4 addr hi");
        xc(8'h20, 8'h20, "R4 addr lo");
        xc(8'h33, 8'h33, "R3 high write data");
        ref_mem[8'h21] = 8'h33;
        end_com();
        xc(8'h03, 8'h03, "R3 read");
        xc(8'h00, 8'h00, "R4");
        xc(8'h40, 8'h40, "R4");
        xc(8'hFF, ref_mem[8'h40], "R4 two address bytes read");
        xc(8'hFF, ref_mem[8'h41], "R5 increment read");
        end_com();
        xc(8'h0B, 8'h0B, "R3 high read opcode");
        xc(8'h00, 8'h00, "R4");
        xc(8'h20, 8'h20, "R4");
        xc(8'hFF, ref_mem[8'h21], "R3 high read seeded with one");
        end_com();
    endtask

    task automatic t_ee3_flash();
        mode = M_EE3;
        xc(8'h02, 8'h02, "R3");
        xc(8'h00, 8'h00, "R4"); xc(8'h00, 8'h00, "R4"); xc(8'h80, 8'h80, "R4");
        xc(8'h44, 8'h44, "R5");
        ref_mem[8'h80] = 8'h44;
        end_com();
        xc(8'h03, 8'h03, "R3");
        xc(8'h00, 8'h00, "R4"); xc(8'h00, 8'h00, "R4"); xc(8'h80, 8'h80, "R4");
        xc(8'hFF, ref_mem[8'h80], "R4 three address bytes read");
        end_com();
        mode = M_FLASH;
        xc(8'h02, 8'h02, "R3 0x02 unknown in flash mode");
        xc(8'h0A, 8'h0A, "R3 flash write opcode");
        xc(8'h00, 8'h00, "R4"); xc(8'h00, 8'h00, "R4"); xc(8'h90, 8'h90, "R4");
        xc(8'h55, 8'h55, "R5 flash write");
        ref_mem[8'h90] = 8'h55;
        end_com();
        xc(8'h03, 8'h03, "R3");
        xc(8'h00, 8'h00, "R4"); xc(8'h00, 8'h00, "R4"); xc(8'h90, 8'h90, "R4");
        xc(8'hFF, ref_mem[8'h90], "R4 flash read, address not seeded");
        end_com();
    endtask

    task automatic t_status();
        mode = M_FLASH;
        xc(8'h05, 8'h05, "R9 status opcode echo");
        xc(8'hFF, 8'h00, "R9 flash status");
        xc(8'hFF, 8'h00, "R9 flash status repeat");
        end_com();
        mode = M_EE1; writable = 1'b1;
        xc(8'h05, 8'h05, "R9");
        xc(8'hFF, 8'h02, "R9 ee status writable");
        writable = 1'b0;
        xc(8'hFF, 8'h00, "R9 ee status not writable");
        end_com();
        writable = 1'b1;
    endtask

    task automatic t_out_of_range();
        mode = M_EE2;
        xc(8'h02, 8'h02, "R6");
        xc(8'h01, 8'h01, "R6"); xc(8'h00, 8'h00, "R6");
        xc(8'h66, 8'h66, "R6 write beyond end echoed");
        end_com();
        xc(8'h03, 8'h03, "R6");
        xc(8'h01, 8'h01, "R6"); xc(8'h00, 8'h00, "R6");
        xc(8'hC3, 8'hC3, "R6 read beyond end echoed");
        end_com();
        mode = M_EE1;
        xc(8'h02, 8'h02, "R6");
        xc(8'hFF, 8'hFF, "R6");
        xc(8'h77, 8'h77, "R6 last cell write");
        ref_mem[8'hFF] = 8'h77;
        xc(8'h88, 8'h88, "R6 write after running off end");
        end_com();
        xc(8'h03, 8'h03, "R6");
        xc(8'hFF, 8'hFF, "R6");
        xc(8'h00, ref_mem[8'hFF], "R6 last cell kept");
        xc(8'h5C, 8'h5C, "R6 read after running off end echoed");
        end_com();
    endtask

    task automatic t_comrst();
        mode = M_EE1; writable = 1'b1;
        xc(8'h06, 8'h06, "R10");
        end_com();
        xc(8'h02, 8'h02, "R10 latch survives com reset");
        xc(8'h10, 8'h10, "R10");
        end_com();
        xc(8'h03, 8'h03, "R10");
        xc(8'h10, 8'h10, "R10");
        xc(8'hFF, ref_mem[8'h10], "R10 stored data survives com reset");
        end_com();
        xc(8'h04, 8'h04, "R7 wrdi echo");
        xc(8'h02, 8'h00, "R7 wrdi clears latch");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1: watchdog expired, got running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle();
        t_refused();
        t_ee1();
        t_ee2_high();
        t_ee3_flash();
        t_status();
        t_out_of_range();
        t_comrst();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule